// File: doc/BRIEF.md
# Memory Stall Attribution Counters

This block sits beside the single valid/ready memory port of an in-order, state-machine CPU and works out where memory waiting time goes. Each request on the port is sorted into one of seven kinds: instruction fetch, data load, data store, atomic operation, page walk started by a fetch, page walk started by a load or store, and other. The kind comes from the core state code and a few side flags. For every kind the block counts the cycles a request waits for ready and the handshakes that complete. It also keeps two totals and a cycle counter for each of six core states.

The kind is fixed in the first cycle of a request and held until the handshake, so a wait is never split across kinds. A request issued during writeback counts as a fetch, because the next fetch may start early. Requests from the floating-point high-half memory state count as loads or stores. All counters are 64 bits wide. Software or a harness reads them through an indexed port that has one cycle of latency. Counting is gated by an enable input and zeroed by a synchronous clear.

Top module: `memstall_attr`

## Requirements
- R1: Every request maps to exactly one kind. Kind codes: 0 fetch, 1 load, 2 store, 3 atomic, 4 walk-for-fetch, 5 walk-for-data, 6 other. The core_state codes are 0 fetch, 1 execute, 2 memory, 3 page walker, 4 writeback, 5 multiply/divide, 6 floating-point high-half memory. Any other code is idle and maps to other. States 1 and 5 also map to other.
- R2: A request issued in state 0 or in writeback (state 4) is an instruction fetch.
- R3: In state 2, mem_atomic=1 gives atomic. Otherwise mem_write selects store (1) or load (0). In state 6, mem_write alone selects store or load, and mem_atomic is ignored.
- R4: In state 3, walk_from_fetch=1 gives walk-for-fetch and 0 gives walk-for-data.
- R5: Each cycle with mem_valid=1 and mem_ready=0 adds one to the stall counter of the request's kind.
- R6: Each cycle with mem_valid=1 and mem_ready=1 adds one to the request counter of that kind.
- R7: The kind is taken in the first valid cycle of a request and held until its handshake, even if core_state or the flags change meanwhile.
- R8: The total stall counter equals the sum of the seven stall counters. The total request counter equals the sum of the seven request counters.
- R9: The state counters each add one per cycle in their state: fetch (0), execute (1), memory (2 or 6), walker (3), writeback (4), multiply/divide (5).
- R10: With cnt_clr=1, every counter is zero after the next clock edge. This holds regardless of cnt_en or traffic.
- R11: With cnt_en=0 and cnt_clr=0, no counter changes.
- R12: rd_data shows the counter selected by rd_idx one clock after rd_idx is presented. The map is: 0..6 stall counter of kind n; 8..14 request counter of kind n-8; 16 total stalls; 17 total requests; 18..23 state counters for fetch, execute, memory, walker, writeback, multiply/divide. Every other index reads zero.
- R13: After reset, all counters and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Counting enable |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| mem_valid | input | 1 | Memory request valid from the core |
| mem_ready | input | 1 | Memory ready toward the core |
| core_state | input | 4 | Core state code |
| mem_atomic | input | 1 | Current access is an atomic operation |
| mem_write | input | 1 | Current access is a write |
| walk_from_fetch | input | 1 | Current page walk was started by a fetch |
| rd_idx | input | 5 | Counter select for readback |
| rd_data | output | 64 | Selected counter value, one cycle later |

## Verification
The assertions assume the port follows the usual valid/ready rule: once mem_valid rises, it stays high until the handshake cycle. Under that rule, holding the kind through a request is well defined. They also assume reset holds mem_valid and cnt_clr low. The stimulus never drops mem_valid mid-wait. It does change core_state and the flags in the middle of a wait, because that is exactly what the hold rule must absorb. Clear and enable changes are made between requests and also during live traffic.

// File: rtl/memstall_pkg.sv
package memstall_pkg;
  localparam int STW    = 4;
  localparam int NKIND  = 7;
  localparam int NSTATE = 6;

  typedef enum logic [2:0] {
    K_FETCH  = 3'd0,
    K_LOAD   = 3'd1,
    K_STORE  = 3'd2,
    K_AMO    = 3'd3,
    K_WALK_I = 3'd4,
    K_WALK_D = 3'd5,
    K_OTHER  = 3'd6
  } kind_t;

  localparam logic [STW-1:0] CS_FETCH  = 4'd0;
  localparam logic [STW-1:0] CS_EXEC   = 4'd1;
  localparam logic [STW-1:0] CS_MEM    = 4'd2;
  localparam logic [STW-1:0] CS_WALK   = 4'd3;
  localparam logic [STW-1:0] CS_WB     = 4'd4;
  localparam logic [STW-1:0] CS_MULDIV = 4'd5;
  localparam logic [STW-1:0] CS_FPHI   = 4'd6;
endpackage

// File: rtl/memstall_classify.sv
module memstall_classify
  import memstall_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] core_state,
  input  logic           mem_atomic,
  input  logic           mem_write,
  input  logic           walk_from_fetch,
  input  logic           mem_valid,
  input  logic           mem_ready,
  output kind_t          act_kind
);
  kind_t fresh_kind;
  kind_t kind_q, kind_d;
  logic  busy_q, busy_d;

  // decode the kind from the current state and side flags
  always_comb begin
    unique case (core_state)
      CS_FETCH, CS_WB: fresh_kind = K_FETCH;
      CS_MEM:          fresh_kind = mem_atomic ? K_AMO : (mem_write ? K_STORE : K_LOAD);
      CS_FPHI:         fresh_kind = mem_write ? K_STORE : K_LOAD;
      CS_WALK:         fresh_kind = walk_from_fetch ? K_WALK_I : K_WALK_D;
      default:         fresh_kind = K_OTHER;
    endcase
  end

  // a waiting request keeps the kind captured in its first cycle
  always_comb begin
    act_kind = busy_q ? kind_q : fresh_kind;
    busy_d   = mem_valid & ~mem_ready;
    kind_d   = mem_valid ? act_kind : kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= K_OTHER;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
    end
  end
endmodule

// File: rtl/memstall_ctr.sv
module memstall_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr)      count_d = '0;
    else if (inc) count_d = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/memstall_attr.sv
module memstall_attr
  import memstall_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic           cnt_clr,
  input  logic           mem_valid,
  input  logic           mem_ready,
  input  logic [STW-1:0] core_state,
  input  logic           mem_atomic,
  input  logic           mem_write,
  input  logic           walk_from_fetch,
  input  logic [4:0]     rd_idx,
  output logic [CW-1:0]  rd_data
);
  localparam int RGW = 2;

  kind_t                     act_kind;
  logic                      stall_ev, req_ev;
  logic [NKIND-1:0]          stall_inc, req_inc;
  logic [NSTATE-1:0]         st_hit;
  logic [NKIND-1:0][CW-1:0]  stall_q, req_q;
  logic [NSTATE-1:0][CW-1:0] state_q;
  logic [CW-1:0]             tot_stall_q, tot_req_q;
  logic [CW-1:0]             rd_d;
  logic [RGW-1:0]            rd_region;
  logic [2:0]                rd_lo, st_sel;

  memstall_classify u_cls (
    .clk             (clk),
    .rst_n           (rst_n),
    .core_state      (core_state),
    .mem_atomic      (mem_atomic),
    .mem_write       (mem_write),
    .walk_from_fetch (walk_from_fetch),
    .mem_valid       (mem_valid),
    .mem_ready       (mem_ready),
    .act_kind        (act_kind)
  );

  assign stall_ev = mem_valid & ~mem_ready;
  assign req_ev   = mem_valid &  mem_ready;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign stall_inc[k] = cnt_en & stall_ev & (act_kind == kind_t'(k));
    assign req_inc[k]   = cnt_en & req_ev   & (act_kind == kind_t'(k));
    memstall_ctr #(.W(CW)) u_stall (
      .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (stall_inc[k]), .count (stall_q[k])
    );
    memstall_ctr #(.W(CW)) u_req (
      .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (req_inc[k]), .count (req_q[k])
    );
  end

  memstall_ctr #(.W(CW)) u_tot_stall (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (cnt_en & stall_ev), .count (tot_stall_q)
  );
  memstall_ctr #(.W(CW)) u_tot_req (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (cnt_en & req_ev), .count (tot_req_q)
  );

  // state residency decode
  always_comb begin
    st_hit = '0;
    unique case (core_state)
      CS_FETCH:         st_hit[0] = 1'b1;
      CS_EXEC:          st_hit[1] = 1'b1;
      CS_MEM, CS_FPHI:  st_hit[2] = 1'b1;
      CS_WALK:          st_hit[3] = 1'b1;
      CS_WB:            st_hit[4] = 1'b1;
      CS_MULDIV:        st_hit[5] = 1'b1;
      default:          st_hit    = '0;
    endcase
  end

  for (genvar s = 0; s < NSTATE; s++) begin : g_state
    memstall_ctr #(.W(CW)) u_st (
      .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (cnt_en & st_hit[s]), .count (state_q[s])
    );
  end

  // readback select
  assign rd_region = rd_idx[4:3];
  assign rd_lo     = rd_idx[2:0];
  assign st_sel    = rd_lo - 3'd2;

  always_comb begin
    rd_d = '0;
    unique case (rd_region)
      2'd0: if (rd_lo < 3'(NKIND)) rd_d = stall_q[rd_lo];
      2'd1: if (rd_lo < 3'(NKIND)) rd_d = req_q[rd_lo];
      2'd2: begin
        if      (rd_lo == 3'd0) rd_d = tot_stall_q;
        else if (rd_lo == 3'd1) rd_d = tot_req_q;
        else                    rd_d = state_q[st_sel];
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/memstall_attr_chk.sv
module memstall_attr_chk
  import memstall_pkg::*;
#(
  parameter int CW = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cnt_en,
  input logic                     cnt_clr,
  input logic                     mem_valid,
  input logic                     mem_ready,
  input logic [4:0]               rd_idx,
  input logic [CW-1:0]            rd_data,
  input kind_t                    act_kind,
  input logic [NKIND-1:0]         stall_inc,
  input logic [NKIND-1:0]         req_inc,
  input logic [NKIND-1:0][CW-1:0] stall_q,
  input logic [NKIND-1:0][CW-1:0] req_q,
  input logic [CW-1:0]            tot_stall_q,
  input logic [CW-1:0]            tot_req_q
);
  function automatic logic [CW-1:0] sum_kinds(input logic [NKIND-1:0][CW-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NKIND; i++) acc = acc + v[i];
    return acc;
  endfunction

  p_one_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && mem_valid) |-> $onehot(stall_inc | req_inc));

  p_stall_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && mem_valid && !mem_ready) |=> tot_stall_q == $past(tot_stall_q) + 1);

  p_req_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && mem_valid && mem_ready) |=> tot_req_q == $past(tot_req_q) + 1);

  p_kind_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_valid && !mem_ready) && mem_valid) |-> act_kind == $past(act_kind));

  p_stall_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tot_stall_q == sum_kinds(stall_q));

  p_req_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tot_req_q == sum_kinds(req_q));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (tot_stall_q == '0 && tot_req_q == '0));

  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> ($stable(tot_stall_q) && $stable(tot_req_q)));

  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= 5'd24 || rd_idx == 5'd7 || rd_idx == 5'd15) |=> rd_data == '0);
endmodule

bind memstall_attr memstall_attr_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_en      (cnt_en),
  .cnt_clr     (cnt_clr),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .rd_idx      (rd_idx),
  .rd_data     (rd_data),
  .act_kind    (act_kind),
  .stall_inc   (stall_inc),
  .req_inc     (req_inc),
  .stall_q     (stall_q),
  .req_q       (req_q),
  .tot_stall_q (tot_stall_q),
  .tot_req_q   (tot_req_q)
);

// File: tb/sim_memstall_attr.sv
`timescale 1ns/1ps
module sim_memstall_attr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en, cnt_clr, mem_valid, mem_ready;
  logic [3:0]  core_state;
  logic        mem_atomic, mem_write, walk_from_fetch;
  logic [4:0]  rd_idx;
  logic [63:0] rd_data;

  int errors = 0;
  int checks = 0;

  logic [63:0] exp_c [32];
  logic        m_busy;
  int          m_kind;

  always #5 clk = ~clk;

  memstall_attr u0 (
    .clk (clk), .rst_n (rst_n), .cnt_en (cnt_en), .cnt_clr (cnt_clr),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .core_state (core_state),
    .mem_atomic (mem_atomic), .mem_write (mem_write),
    .walk_from_fetch (walk_from_fetch), .rd_idx (rd_idx), .rd_data (rd_data)
  );

  // request table: {state[3:0], atomic, write, walk_from_fetch, wait[3:0]}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {4'd0,  1'b0, 1'b0, 1'b0, 4'd2},
    {4'd2,  1'b0, 1'b0, 1'b0, 4'd3},
    {4'd2,  1'b0, 1'b1, 1'b0, 4'd1},
    {4'd2,  1'b1, 1'b1, 1'b0, 4'd2},
    {4'd3,  1'b0, 1'b0, 1'b1, 4'd1},
    {4'd3,  1'b0, 1'b0, 1'b0, 4'd4},
    {4'd4,  1'b0, 1'b0, 1'b0, 4'd0},
    {4'd6,  1'b0, 1'b0, 1'b0, 4'd2},
    {4'd6,  1'b1, 1'b1, 1'b0, 4'd1},
    {4'd1,  1'b0, 1'b0, 1'b0, 4'd3},
    {4'd5,  1'b1, 1'b0, 1'b0, 4'd0},
    {4'd15, 1'b0, 1'b0, 1'b0, 4'd1}
  };

  function automatic int kind_of(input logic [3:0] st, input logic atm, input logic wr, input logic wf);
    case (st)
      4'd0, 4'd4: return 0;
      4'd2:       return atm ? 3 : (wr ? 2 : 1);
      4'd6:       return wr ? 2 : 1;
      4'd3:       return wf ? 4 : 5;
      default:    return 6;
    endcase
  endfunction

  function automatic int state_slot(input logic [3:0] st);
    case (st)
      4'd0:       return 18;
      4'd1:       return 19;
      4'd2, 4'd6: return 20;
      4'd3:       return 21;
      4'd4:       return 22;
      4'd5:       return 23;
      default:    return -1;
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    if (idx < 8)        return "R5";
    else if (idx < 16)  return "R6";
    else if (idx < 18)  return "R8";
    else if (idx < 24)  return "R9";
    else                return "R12";
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: update the model from the driven inputs, then step
  task automatic tick();
    int k;
    int s;
    if (cnt_clr) begin
      for (int i = 0; i < 32; i++) exp_c[i] = '0;
    end else if (cnt_en) begin
      s = state_slot(core_state);
      if (s >= 0) exp_c[s] = exp_c[s] + 1;
      if (mem_valid) begin
        k = m_busy ? m_kind : kind_of(core_state, mem_atomic, mem_write, walk_from_fetch);
        if (mem_ready) begin exp_c[8+k] = exp_c[8+k] + 1; exp_c[17] = exp_c[17] + 1; end
        else           begin exp_c[k]   = exp_c[k]   + 1; exp_c[16] = exp_c[16] + 1; end
      end
    end
    if (mem_valid) begin
      if (!m_busy) m_kind = kind_of(core_state, mem_atomic, mem_write, walk_from_fetch);
      m_busy = !mem_ready;
    end else begin
      m_busy = 1'b0;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    mem_valid = 1'b0; mem_ready = 1'b0; core_state = 4'd15;
    mem_atomic = 1'b0; mem_write = 1'b0; walk_from_fetch = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] v);
    idle();
    rd_idx = 5'(idx);
    tick();
    v = rd_data;
  endtask

  task automatic compare_all(input string what);
    logic [63:0] v;
    logic [63:0] e;
    for (int i = 0; i < 32; i++) begin
      e = exp_c[i];
      rd(i, v);
      check(v, e, tag_of(i), $sformatf("%s idx %0d", what, i));
    end
  endtask

  task automatic request(input logic [3:0] st, input logic atm, input logic wr,
                         input logic wf, input int waits);
    core_state = st; mem_atomic = atm; mem_write = wr; walk_from_fetch = wf;
    mem_valid = 1'b1; mem_ready = 1'b0;
    for (int w = 0; w < waits; w++) tick();
    mem_ready = 1'b1;
    tick();
    idle();
  endtask

  task automatic pulse_clear();
    idle();
    cnt_clr = 1'b1;
    tick();
    cnt_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] snap;
    for (int i = 0; i < 32; i++) exp_c[i] = '0;
    m_busy = 1'b0; m_kind = 6;
    rst_n = 1'b0; cnt_en = 1'b1; cnt_clr = 1'b0; rd_idx = '0;
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R13: everything zero after reset
    rd(16, v); check(v, 64'd0, "R13", "reset total stall");
    rd(22, v); check(v, 64'd0, "R13", "reset writeback cycles");

    // table of requests, one after another
    for (int n = 0; n < NV; n++)
      request(VEC[n][10:7], VEC[n][6], VEC[n][5], VEC[n][4], int'(VEC[n][3:0]));
    rd(17, v); check(v, 64'(NV), "R1", "one kind per request, total requests");
    compare_all("table");

    // R2/R3/R4 directed after a clear
    pulse_clear();
    request(4'd4, 1'b0, 1'b0, 1'b0, 1);
    request(4'd6, 1'b1, 1'b1, 1'b0, 2);
    request(4'd3, 1'b0, 1'b0, 1'b1, 3);
    rd(0, v);  check(v, 64'd1, "R2", "writeback request stalls as fetch");
    rd(8, v);  check(v, 64'd1, "R2", "writeback request counted as fetch");
    rd(2, v);  check(v, 64'd2, "R3", "fp high-half store stalls");
    rd(3, v);  check(v, 64'd0, "R3", "atomic flag ignored in fp high-half");
    rd(4, v);  check(v, 64'd3, "R4", "walk from fetch stalls");
    rd(5, v);  check(v, 64'd0, "R4", "walk for data untouched");

    // R7: state changes mid-wait, kind stays load
    pulse_clear();
    core_state = 4'd2; mem_write = 1'b0; mem_atomic = 1'b0; mem_valid = 1'b1; mem_ready = 1'b0;
    tick(); tick();
    core_state = 4'd1; mem_write = 1'b1; mem_atomic = 1'b1;
    tick();
    mem_ready = 1'b1;
    tick();
    idle();
    rd(1, v);  check(v, 64'd3, "R7", "held load stall count");
    rd(9, v);  check(v, 64'd1, "R7", "held load request count");
    rd(6, v);  check(v, 64'd0, "R7", "nothing moved to other");
    rd(19, v); check(v, 64'd2, "R9", "execute cycles during wait");
    compare_all("hold");

    // back-to-back requests with no idle gap, fresh capture each time
    core_state = 4'd2; mem_write = 1'b1; mem_valid = 1'b1; mem_ready = 1'b0;
    tick();
    mem_ready = 1'b1; tick();
    core_state = 4'd0; mem_write = 1'b0; mem_ready = 1'b0;
    tick(); tick();
    mem_ready = 1'b1; tick();
    idle();
    compare_all("back-to-back");

    // R11: enable low freezes
    rd(16, snap);
    cnt_en = 1'b0;
    request(4'd2, 1'b0, 1'b0, 1'b0, 3);
    request(4'd0, 1'b0, 1'b0, 1'b0, 2);
    rd(16, v); check(v, snap, "R11", "total stall frozen");
    compare_all("frozen");
    cnt_en = 1'b1;

    // R10: clear during live stall, with enable high, wins
    core_state = 4'd3; walk_from_fetch = 1'b0; mem_valid = 1'b1; mem_ready = 1'b0;
    tick();
    cnt_clr = 1'b1;
    tick();
    cnt_clr = 1'b0;
    mem_ready = 1'b1;
    tick();
    idle();
    rd(5, v);  check(v, 64'd0, "R10", "walk stall after clear");
    rd(13, v); check(v, 64'd1, "R10", "walk request after clear");
    compare_all("clear");

    // R12: latency, the output follows the index one cycle later
    rd_idx = 5'd17;
    tick();
    rd_idx = 5'd31;
    #2;
    check(rd_data, exp_c[17], "R12", "value of previous index still shown");
    tick();
    check(rd_data, 64'd0, "R12", "unmapped index reads zero");

    summary();
    $finish;
  end
endmodule